// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This unit sits on the data path between a processor's load/store port and a word-addressed memory or peripheral port. It watches every request for two alias windows of 32 MB each. Any word access that lands in a window is turned into an operation on one bit of the matching 1 MB real region. A read of an alias word returns that bit as 0 or 1. A write of an alias word sets or clears that bit with a hardware read-modify-write. The memory port is locked from the read until the write is done, so no other master can slip in between the two halves.

Software can therefore flip a single flag in SRAM or in a peripheral register with one plain store and no masking sequence. Requests outside both windows reach the memory port combinationally and unchanged, and their response comes back the same way.

Both ports use a valid/ready request channel. A request is held stable while valid is high and completes on the cycle where ready is high. Read data is valid in that same cycle.

Top module: `bitband_bridge`

## Requirements
- R1: A request whose address lies in 0x22000000..0x23FFFFFF (SRAM window, real region 0x20000000..0x200FFFFF) or 0x42000000..0x43FFFFFF (peripheral window, real region 0x40000000..0x400FFFFF) is handled as an alias access. Addresses just outside these ranges, such as 0x21FFFFFC and 0x44000000, are passed through.
- R2: A pass-through request appears at the memory port in the same cycle with the same address, write data and write enable. The memory ready and read data are returned to the processor in the same cycle.
- R3: For an alias access, the real byte address is formed from bits [31:28] of the alias address followed by the byte offset in alias bits [24:5]. The bridge reads the word at that byte address with bits [1:0] cleared.
- R4: An alias read returns 0x00000001 when the selected bit is set and 0x00000000 when it is clear. The selected bit is bit (real_byte[1:0]*8 + alias[4:2]) of the memory word. For example, alias 0x22006008 reads bit 2 of the word at 0x20000300.
- R5: An alias write issues exactly one memory read and then exactly one memory write to the same word. The new value of the selected bit is bit 0 of the write data (1 sets, 0 clears). Bits [31:1] of the write data are ignored.
- R6: An alias write leaves every other bit of the target word unchanged.
- R7: The lock output is high during both memory handshakes of an alias write. It is low during alias reads, pass-through accesses and the response cycle.
- R8: The processor sees ready for an alias write only after the memory has acknowledged the write. While the memory inserts wait states, the bridge holds its request and address stable.
- R9: After reset the bridge is idle: the lock output is low, and there is no memory request and no processor ready while no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Processor request complete |
| cpu_addr | input | 32 | Processor byte address |
| cpu_we | input | 1 | Processor write enable |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data to processor, valid with cpu_ready |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request complete |
| mem_addr | output | 32 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |
| mem_lock | output | 1 | Memory port held for an atomic sequence |

## Verification
Suppose the sequencer latched the wrong bit index or word. The first alias read would then return the wrong 0/1 value, and the first alias write would change a neighbouring bit. Both show up in the backing memory as soon as that transaction completes.

Suppose it left its busy states too early or too late. The write counter would be out of step at the moment the processor sees ready, or the lock count per transaction would differ from two or zero. A stuck state would stall the next pass-through access, which the watchdog then catches. Wait-state runs show whether the held memory request stays put across stalls.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int          DATA_W     = 32,
  parameter logic [6:0]  SRAM_TAG   = 7'h11,
  parameter logic [6:0]  PERIPH_TAG = 7'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [31:0]       cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [31:0]       mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_lock
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MODWR, ST_RESP} st_t;

  st_t               st;
  logic [31:0]       word_q;
  logic [IDX_W-1:0]  bit_q;
  logic              wr_q, val_q;
  logic [DATA_W-1:0] rd_q;

  wire alias_hit = (cpu_addr[31:25] == SRAM_TAG) || (cpu_addr[31:25] == PERIPH_TAG);
  wire [31:0] real_byte = {cpu_addr[31:28], 8'h00, cpu_addr[24:5]};
  wire pass = (st == ST_IDLE) && !alias_hit;
  wire busy_mem = (st == ST_READ) || (st == ST_MODWR);

  wire [DATA_W-1:0] bit_mask = DATA_W'(1) << bit_q;
  wire [DATA_W-1:0] mod_word = val_q ? (rd_q | bit_mask) : (rd_q & ~bit_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      word_q <= '0;
      bit_q  <= '0;
      wr_q   <= 1'b0;
      val_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cpu_valid && alias_hit) begin
          word_q <= {real_byte[31:BYTE_W], BYTE_W'(0)};
          bit_q  <= {real_byte[BYTE_W-1:0], cpu_addr[4:2]};
          wr_q   <= cpu_we;
          val_q  <= cpu_wdata[0];
          st     <= ST_READ;
        end
        ST_READ: if (mem_ready) begin
          rd_q <= mem_rdata;
          st   <= wr_q ? ST_MODWR : ST_RESP;
        end
        ST_MODWR: if (mem_ready) st <= ST_RESP;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid = pass ? cpu_valid : busy_mem;
  assign mem_addr  = pass ? cpu_addr  : word_q;
  assign mem_we    = pass ? cpu_we    : (st == ST_MODWR);
  assign mem_wdata = pass ? cpu_wdata : mod_word;
  assign mem_lock  = wr_q && busy_mem;
  assign cpu_ready = pass ? mem_ready : (st == ST_RESP);
  assign cpu_rdata = pass ? mem_rdata :
                     ((st == ST_RESP) && !wr_q) ? DATA_W'(rd_q[bit_q]) : '0;

  AST_ALIAS_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cpu_valid && alias_hit) |-> !mem_valid); // R1
  AST_READ_IS_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !pass) |-> (cpu_rdata[DATA_W-1:1] == '0)); // R4
  AST_WRITE_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MODWR) |-> (mem_addr == $past(mem_addr))); // R5
  AST_ONE_BIT_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MODWR) |-> ($countones(mem_wdata ^ rd_q) <= 1)); // R6
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && !pass) |-> mem_lock); // R7
  AST_LOCK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RESP) |-> !mem_lock); // R7
  AST_ACK_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RESP && wr_q) |-> $past(mem_valid && mem_ready && mem_we)); // R8
  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !pass) |=> (mem_valid && $stable(mem_addr))); // R8
endmodule

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/1ps
module bitband_bridge_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_we = 1'b0, cpu_ready;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
  logic mem_valid, mem_we, mem_lock;
  logic mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  int n_rd = 0, n_wr = 0, n_lock = 0, lat = 0, wcnt = 0;
  int wr_at_ready = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] mem [256];

  always #4 clk = ~clk;

  bitband_bridge u_bitband_bridge (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_lock(mem_lock)
  );

  function automatic int idx(logic [31:0] a);
    return {a[30], a[8:2]};
  endfunction
  function automatic logic [31:0] exp_word(logic [31:0] al);
    logic [31:0] rb = {al[31:28], 8'h00, al[24:5]};
    return {rb[31:2], 2'b00};
  endfunction
  function automatic int exp_bit(logic [31:0] al);
    return al[6:5] * 8 + al[4:2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ready <= 1'b0; mem_rdata <= '0; wcnt <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
    end else if (mem_valid) begin
      if (wcnt >= lat) begin
        mem_ready <= 1'b1;
        wcnt      <= 0;
        mem_rdata <= mem[idx(mem_addr)];
        last_addr <= mem_addr;
        if (mem_we) begin mem[idx(mem_addr)] <= mem_wdata; n_wr <= n_wr + 1; end
        else n_rd <= n_rd + 1;
        if (mem_lock) n_lock <= n_lock + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(logic [31:0] a, logic we, logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    cpu_addr = a; cpu_we = we; cpu_wdata = wd; cpu_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (cpu_ready) break;
    end
    rd = cpu_rdata;
    wr_at_ready = n_wr;
    @(posedge clk); #1;
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 lock", {31'b0, mem_lock}, 0);
    chk("R9 mem_valid", {31'b0, mem_valid}, 0);
    chk("R9 cpu_ready", {31'b0, cpu_ready}, 0);
  endtask

  task automatic t_pass;
    logic [31:0] rd;
    int w0, l0;
    w0 = n_wr; l0 = n_lock;
    xfer(32'h2000_0010, 1'b1, 32'hCAFE_F00D, rd);
    chk("R2 write addr", last_addr, 32'h2000_0010);
    chk("R2 write data", mem[idx(32'h2000_0010)], 32'hCAFE_F00D);
    chk("R2 one write", n_wr - w0, 1);
    xfer(32'h2000_0010, 1'b0, 32'h0, rd);
    chk("R2 read data", rd, 32'hCAFE_F00D);
    chk("R7 no lock on pass", n_lock - l0, 0);
  endtask

  task automatic t_bounds;
    logic [31:0] rd;
    mem[idx(32'h21FF_FFFC)] = 32'h1234_5678;
    xfer(32'h21FF_FFFC, 1'b0, 0, rd);
    chk("R1 below window addr", last_addr, 32'h21FF_FFFC);
    chk("R1 below window data", rd, 32'h1234_5678);
    mem[idx(32'h4400_0000)] = 32'h8765_4321;
    xfer(32'h4400_0000, 1'b0, 0, rd);
    chk("R1 above window addr", last_addr, 32'h4400_0000);
    chk("R1 above window data", rd, 32'h8765_4321);
  endtask

  task automatic t_alias_read(logic [31:0] al, logic [31:0] word);
    logic [31:0] rd;
    int r0, w0, l0;
    mem[idx(exp_word(al))] = word;
    r0 = n_rd; w0 = n_wr; l0 = n_lock;
    xfer(al, 1'b0, 32'hFFFF_FFFF, rd);
    chk("R3 word addr", last_addr, exp_word(al));
    chk("R4 bit value", rd, {31'b0, word[exp_bit(al)]});
    chk("R3 one read", n_rd - r0, 1);
    chk("R3 no write", n_wr - w0, 0);
    chk("R7 no lock on read", n_lock - l0, 0);
  endtask

  task automatic t_alias_write(logic [31:0] al, logic [31:0] word, logic [31:0] wd);
    logic [31:0] rd, exp;
    int r0, w0, l0;
    mem[idx(exp_word(al))] = word;
    exp = word;
    exp[exp_bit(al)] = wd[0];
    r0 = n_rd; w0 = n_wr; l0 = n_lock;
    xfer(al, 1'b1, wd, rd);
    chk("R5 one read", n_rd - r0, 1);
    chk("R5 one write", n_wr - w0, 1);
    chk("R5 word addr", last_addr, exp_word(al));
    chk("R6 word after write", mem[idx(exp_word(al))], exp);
    chk("R7 lock both phases", n_lock - l0, 2);
    chk("R8 ack before ready", wr_at_ready - w0, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_pass();
    t_bounds();
    t_alias_read(32'h2200_6008, 32'h0000_0004);
    t_alias_read(32'h2200_6008, 32'hFFFF_FFFB);
    t_alias_read(32'h4200_0004, 32'h0000_0002);
    t_alias_read(32'h2200_007C, 32'h8000_0000);
    t_alias_write(32'h4200_0004, 32'hA5A5_A5A5, 32'h0000_0001);
    t_alias_write(32'h2200_6008, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
    t_alias_write(32'h2200_0060, 32'h0000_0000, 32'hFFFF_FFFF);
    lat = 3;
    t_alias_write(32'h2200_0024, 32'h1234_5678, 32'h0000_0000);
    t_alias_write(32'h4200_01FC, 32'h0F0F_0F0F, 32'h0000_0001);
    t_alias_read(32'h4200_01FC, 32'h7FFF_FFFF);
    t_pass();
    lat = 0;
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule